// File: doc/BRIEF.md
# Memory Block Attribute Controller

This block holds the attribute settings of an 8 KB array that is split into sixteen blocks of 512 bytes. It records one block as the high-endurance block and a run of blocks as the security-protected range. For any address on its query input, it reports two flags to a write path: whether the address is write-protected and whether it lies in the high-endurance block.

Settings change through a one-cycle configuration command that carries a command byte and an address. Bit 7 of the command byte selects the kind of command. When bit 7 is 0, the command moves the high-endurance block. When bit 7 is 1, the command sets the security range.

The high-endurance attribute always wins over protection. Once a security range of nonzero length has been accepted, the high-endurance location is frozen until the next reset.

Top module: `mem_attr_ctrl`

## Requirements
- R1: After reset, the high-endurance block is block 15 (addresses 0x1E00 to 0x1FFF). The security length is zero and the controller is unlocked, so `wp_o` is 0 for every address and `he_o` is 1 only in block 15.
- R2: A command with `cfg_valid`=1 and `cfg_byte[7]`=0, accepted while unlocked, makes block `cfg_addr[12:9]` the high-endurance block.
- R3: A command with `cfg_valid`=1 and `cfg_byte[7]`=1 sets the security start block to `cfg_addr[12:9]` and the security length to `cfg_byte[3:0]` blocks. Block i is in the range when start <= i < start+length. The range stops at block 15 and does not wrap to block 0.
- R4: `wp_o` is 1 for an address whose block (`qry_addr[12:9]`) is in the security range and is not the high-endurance block. Otherwise `wp_o` is 0.
- R5: `he_o` is 1 exactly when the queried block is the high-endurance block, even if that block is also in the security range. `wp_o` and `he_o` are never both 1.
- R6: Accepting a security command with nonzero length locks the controller. While locked, commands with `cfg_byte[7]`=0 leave the high-endurance block unchanged, and the lock holds until reset.
- R7: A security command with length 0 empties the range and does not lock. Later relocation commands still take effect.
- R8: While `cfg_valid` is 0, the values on `cfg_byte` and `cfg_addr` change no setting.
- R9: An accepted command is reflected on `wp_o` and `he_o` from the first clock edge that samples it. The flags follow `qry_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_byte | input | 8 | Command byte: bit 7 selects the kind, bits 3:0 give the security length |
| cfg_addr | input | 13 | Command address: bits 12:9 give the block |
| qry_addr | input | 13 | Address whose attributes are reported |
| wp_o | output | 1 | Write protect for `qry_addr` |
| he_o | output | 1 | High endurance for `qry_addr` |

## Verification
The attribute outputs are probed across all sixteen blocks under several conditions:
- the reset state;
- a moved high-endurance block;
- a security range that overlaps the high-endurance block, which separates correct precedence from a plain OR of the two attributes;
- a range that runs past the top block, which separates clamping from wraparound.

Relocation is tried before and after a zero-length security command and after a nonzero one, which shows that only a nonzero length freezes the location. Commands with the strobe low show that bus values alone are ignored. Random command sequences, with resets between them, are compared against a bench model.

// File: rtl/mba_pkg.sv
// Package: shared widths and the settings record of the attribute controller.
// Assumes a 13-bit byte address and 16 blocks of 512 bytes.
package mba_pkg;
    localparam int ADDR_W  = 13;
    localparam int BLK_W   = 4;
    localparam int LEN_W   = 4;
    localparam int KIND_BIT = 7;

    typedef struct packed {
        logic [BLK_W-1:0] he_blk;
        logic [BLK_W-1:0] sec_start;
        logic [LEN_W-1:0] sec_len;
        logic             locked;
    } attr_state_t;
endpackage

// File: rtl/mba_cfg_regs.sv
// Module: mba_cfg_regs
// Holds the high-endurance block, the security range and the lock flag, and
// applies one configuration command per cycle. Assumes the command fields are
// already split into block number, kind bit and length.
module mba_cfg_regs
    import mba_pkg::*;
#(
    parameter int BW = BLK_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_kind,
    input  logic [BW-1:0] cmd_blk,
    input  logic [LW-1:0] cmd_len,
    output attr_state_t   st
);
    localparam logic [BW-1:0] TOP_BLK = '1;

    // Update the settings on reset or on an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.he_blk    <= TOP_BLK;
            st.sec_start <= '0;
            st.sec_len   <= '0;
            st.locked    <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd_kind) begin
                st.sec_start <= cmd_blk;
                st.sec_len   <= cmd_len;
                if (cmd_len != '0)
                    st.locked <= 1'b1;
            end else if (!st.locked) begin
                st.he_blk <= cmd_blk;
            end
        end
    end
endmodule

// File: rtl/mba_region_decode.sv
// Module: mba_region_decode
// Compares a queried block with the stored settings. It builds a per-block
// mask of the security range, clamped at the top block, and matches the
// high-endurance block. Assumes LW <= BW.
module mba_region_decode
    import mba_pkg::*;
#(
    parameter int BW = BLK_W,
    parameter int LW = LEN_W
) (
    input  attr_state_t   st,
    input  logic [BW-1:0] qry_blk,
    output logic          sec_hit,
    output logic          he_hit
);
    localparam int NUM_BLK = 1 << BW;
    localparam int EXT_W   = BW + 1;

    logic [EXT_W-1:0]   range_end;
    logic [NUM_BLK-1:0] sec_mask;

    // Exclusive end of the range, one bit wider so it cannot wrap.
    always_comb range_end = EXT_W'(st.sec_start) + EXT_W'(st.sec_len);

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        // Block i lies in the range when start <= i < end.
        always_comb sec_mask[i] = (EXT_W'(i) >= EXT_W'(st.sec_start)) &&
                                  (EXT_W'(i) < range_end);
    end

    // Look up the queried block.
    always_comb begin
        sec_hit = sec_mask[qry_blk];
        he_hit  = (qry_blk == st.he_blk);
    end
endmodule

// File: rtl/mba_attr_merge.sv
// Module: mba_attr_merge
// Combines the two region hits into the output flags. High endurance takes
// precedence, so it masks write protection.
module mba_attr_merge (
    input  logic sec_hit,
    input  logic he_hit,
    output logic wp,
    output logic he
);
    // Apply the precedence rule.
    always_comb begin
        he = he_hit;
        wp = sec_hit && !he_hit;
    end
endmodule

// File: rtl/mem_attr_ctrl.sv
// Module: mem_attr_ctrl (top)
// Attribute controller for an array of 16 blocks of 512 bytes. Takes
// configuration commands and reports write-protect and high-endurance flags
// for a queried address. Assumes a synchronous active-low reset.
module mem_attr_ctrl
    import mba_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BLK_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic [7:0]    cfg_byte,
    input  logic [AW-1:0] cfg_addr,
    input  logic [AW-1:0] qry_addr,
    output logic          wp_o,
    output logic          he_o
);
    localparam int BLK_LSB = AW - BW;

    attr_state_t state;
    logic        sec_hit;
    logic        he_hit;
    logic        unused_bits;

    // Fold the address and byte bits this block ignores into one sink.
    always_comb unused_bits = ^{cfg_byte[6:LW], cfg_addr[BLK_LSB-1:0], qry_addr[BLK_LSB-1:0]};

    mba_cfg_regs #(.BW(BW), .LW(LW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cfg_valid),
        .cmd_kind  (cfg_byte[KIND_BIT]),
        .cmd_blk   (cfg_addr[AW-1:BLK_LSB]),
        .cmd_len   (cfg_byte[LW-1:0]),
        .st        (state)
    );

    mba_region_decode #(.BW(BW), .LW(LW)) u_dec (
        .st      (state),
        .qry_blk (qry_addr[AW-1:BLK_LSB]),
        .sec_hit (sec_hit),
        .he_hit  (he_hit)
    );

    mba_attr_merge u_merge (
        .sec_hit (sec_hit),
        .he_hit  (he_hit),
        .wp      (wp_o),
        .he      (he_o)
    );
endmodule

// File: rtl/mba_checker.sv
// Module: mba_checker
// Property checks for mem_attr_ctrl, attached to the top through a bind.
// It sees the stored settings through the top's state signal.
module mba_checker
    import mba_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_valid,
    input logic [7:0]  cfg_byte,
    input logic [12:0] cfg_addr,
    input attr_state_t st,
    input logic        wp_o,
    input logic        he_o
);
    // The two output flags are never both set.
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wp_o && he_o));

    // Once set, the lock holds until reset.
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st.locked |=> st.locked);

    // While locked, a relocation command leaves the block unchanged.
    assert_locked_he_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st.locked && cfg_valid && !cfg_byte[7]) |=> $stable(st.he_blk));

    // An unlocked relocation command takes the block from the address.
    assert_he_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.locked && cfg_valid && !cfg_byte[7]) |=> (st.he_blk == $past(cfg_addr[12:9])));

    // With the strobe low, no setting changes.
    assert_idle_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> ($stable(st.he_blk) && $stable(st.sec_start) && $stable(st.sec_len)));

    // A zero-length security command does not create a lock.
    assert_zero_len_no_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.locked && cfg_valid && cfg_byte[7] && cfg_byte[3:0] == 4'd0) |=> !st.locked);
endmodule

bind mem_attr_ctrl mba_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_byte  (cfg_byte),
    .cfg_addr  (cfg_addr),
    .st        (state),
    .wp_o      (wp_o),
    .he_o      (he_o)
);

// File: tb/sim_mem_attr_ctrl.sv
// Bench for mem_attr_ctrl: directed corner cases plus seeded random commands,
// compared with a bench model built from the requirements.
module sim_mem_attr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic [12:0] cfg_addr = '0;
    logic [12:0] qry_addr = '0;
    logic        wp_o, he_o;

    int checks = 0;
    int errors = 0;

    // Bench model of the settings.
    int m_he, m_start, m_len;
    bit m_lock;

    mem_attr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
        .cfg_addr(cfg_addr), .qry_addr(qry_addr), .wp_o(wp_o), .he_o(he_o)
    );

    always #10 clk = ~clk;

    function automatic bit exp_he(int blk);
        return blk == m_he;
    endfunction

    function automatic bit exp_wp(int blk);
        return (blk >= m_start) && (blk < m_start + m_len) && (blk != m_he);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_he = 15; m_start = 0; m_len = 0; m_lock = 0;
    endtask

    task automatic cmd(input logic [7:0] b, input logic [12:0] a, input bit strobe);
        @(negedge clk);
        cfg_valid = strobe;
        cfg_byte  = b;
        cfg_addr  = a;
        @(negedge clk);
        cfg_valid = 1'b0;
        if (strobe) begin
            if (b[7]) begin
                m_start = int'(a[12:9]);
                m_len   = int'(b[3:0]);
                if (b[3:0] != 0) m_lock = 1;
            end else if (!m_lock) begin
                m_he = int'(a[12:9]);
            end
        end
    endtask

    task automatic probe(input logic [12:0] a, input string req);
        int blk;
        blk = int'(a[12:9]);
        qry_addr = a;
        #1;
        checks++;
        if (wp_o !== exp_wp(blk) || he_o !== exp_he(blk)) begin
            errors++;
            $display("FAIL %s addr=%h wp/he actual=%b%b expected=%b%b",
                     req, a, wp_o, he_o, exp_wp(blk), exp_he(blk));
        end
    endtask

    task automatic sweep(input string req);
        for (int b = 0; b < 16; b++)
            probe({b[3:0], 9'($urandom_range(0, 511))}, req);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #3_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        sweep("R1");
        probe(13'h1E00, "R1");
        probe(13'h1FFF, "R1");
        probe(13'h1DFF, "R1");
        // Relocate the block, then probe it in the same cycle as the update (R9).
        cmd(8'h00, 13'h0600, 1);
        sweep("R2 R9");
        // Strobe low: the bus values must be ignored (R8).
        cmd(8'h8F, 13'h0000, 0);
        sweep("R8");
        cmd(8'h00, 13'h1000, 0);
        sweep("R8");
        // A zero-length range does not lock, so relocation still works (R7).
        cmd(8'h80, 13'h0400, 1);
        sweep("R7");
        cmd(8'h00, 13'h0800, 1);
        sweep("R7");
        // The range overlaps the block: precedence (R4, R5).
        cmd(8'h83, 13'h0600, 1);
        sweep("R4 R5");
        // Locked: relocation is ignored (R6).
        cmd(8'h00, 13'h0000, 1);
        sweep("R6");
        // A range past the top block must not wrap (R3).
        cmd(8'h85, 13'h1C00, 1);
        sweep("R3");
        cmd(8'h00, 13'h0200, 1);
        sweep("R6");
        // Reset clears the lock (R1, R6).
        do_reset();
        cmd(8'h00, 13'h0200, 1);
        sweep("R1 R6");
        // Random command sequences with occasional resets.
        for (int it = 0; it < 400; it++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if ($urandom_range(0, 3) != 0) b[3:0] = 4'd0;
            if ($urandom_range(0, 30) == 0) do_reset();
            cmd(b, 13'($urandom), $urandom_range(0, 4) != 0);
            for (int q = 0; q < 4; q++) probe(13'($urandom), "R3 R4 R5 R6");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule